// File: doc/BRIEF.md
# Round-Robin Phase Selector

This block spreads the switching pulses of a multiphase converter across its enabled phases. One pulse request comes in. The block routes it to the phase that is currently selected and shows it as a one-hot bit on an eight-bit high-side vector. When the request ends, the selection steps to the next enabled phase. After the last enabled phase it wraps back to phase 0.

A three-bit field sets how many phases take part. A second option decides what happens to the phases that do not take part: they are either released (output enable low) or held actively low. A sequencer input marks the interval in which rotation is allowed. Outside that interval the selection is parked at phase 0 and requests are ignored.

All pins are plain control and status levels. The pulse request is a level that lasts one or more cycles. It has no ready or back-pressure, because a switching event cannot be delayed.

Top module: `phase_rotator`

## Requirements
- R1: After reset, `hs_out` is all zeros and the first accepted pulse is routed to phase 0.
- R2: While `pulse_req` and `seq_active` are both high, `hs_out` has exactly the bit of the current phase set. In every other cycle `hs_out` is all zeros.
- R3: The current phase advances by one in the cycle after an accepted request falls. Once the configured last phase has been served, it wraps to 0.
- R4: `cfg_last_ph` encodes the phase count minus one. A value k (0 to 7) makes phases 0..k take part in the rotation.
- R5: If `cfg_last_ph` is lowered below the current phase, the next accepted pulse goes to phase 0, and rotation continues from there.
- R6: While `seq_active` is low, the current phase is returned to 0. A `pulse_req` in that time drives no `hs_out` bit and does not advance the rotation.
- R7: `hs_oe[i]` is high for every phase i with i <= `cfg_last_ph`.
- R8: For every phase i > `cfg_last_ph`, `hs_out[i]` stays 0 and `hs_oe[i]` equals `cfg_unused_low`.
- R9: A request that stays high for several cycles keeps the same single phase bit set for its whole duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_active | input | 1 | High while the sequencer allows pulses (soft-start or run) |
| pulse_req | input | 1 | Pulse request level |
| cfg_last_ph | input | 3 | Number of phases minus one |
| cfg_unused_low | input | 1 | Drive unused phases low instead of releasing them |
| hs_out | output | 8 | One-hot high-side pulse vector |
| hs_oe | output | 8 | Per-phase output enable |

## Verification
Single-cycle pulses are sent under every phase-count setting, each run long enough to wrap at least twice. This separates a correct wrap point from an off-by-one. Multi-cycle pulses show whether the rotation steps at the end of a request or on every cycle. Lowering the phase count while the selection sits past the new limit, and dropping the sequencer mid-rotation with requests still arriving, test the two recovery paths back to phase 0. Sweeping both settings of the unused-phase option against every count exercises the enable mask bit by bit.

// File: rtl/phs_pkg.sv
package phs_pkg;
  localparam int unsigned NPH = 8;
  localparam int unsigned IW  = $clog2(NPH);
  typedef logic [IW-1:0] ph_idx_t;
  typedef logic [NPH-1:0] ph_vec_t;
endpackage

// File: rtl/phs_counter.sv
module phs_counter #(
  parameter int unsigned NPH = 8,
  localparam int unsigned IW = $clog2(NPH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seq_active,
  input  logic          req,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] idx_o,
  output logic          acc_o
);
  logic [IW-1:0] idx_q;
  logic          req_q;
  logic          acc;
  logic [IW-1:0] eff;

  assign acc   = req & seq_active;
  // an index past a lowered limit folds back to phase 0
  assign eff   = (idx_q > last) ? '0 : idx_q;
  assign idx_o = eff;
  assign acc_o = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      req_q <= 1'b0;
    end else if (!seq_active) begin
      idx_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= acc;
      if (req_q && !acc)
        idx_q <= (eff == last) ? '0 : eff + IW'(1);
    end
  end

  p_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_active |=> idx_q == '0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && acc) |=> $stable(idx_q));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !acc && seq_active && last != '0) |=> idx_q != $past(idx_q));

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && seq_active) |=> $stable(idx_q));
endmodule

// File: rtl/phs_onehot.sv
module phs_onehot #(
  parameter int unsigned NPH = 8,
  localparam int unsigned IW = $clog2(NPH)
) (
  input  logic [IW-1:0]  idx,
  input  logic           en,
  output logic [NPH-1:0] vec
);
  for (genvar i = 0; i < NPH; i++) begin : g_bit
    assign vec[i] = en && (idx == IW'(i));
  end
endmodule

// File: rtl/phs_oe_mask.sv
module phs_oe_mask #(
  parameter int unsigned NPH = 8,
  localparam int unsigned IW = $clog2(NPH)
) (
  input  logic [IW-1:0]  last,
  input  logic           force_low,
  output logic [NPH-1:0] oe
);
  for (genvar i = 0; i < NPH; i++) begin : g_oe
    assign oe[i] = (last >= IW'(i)) || force_low;
  end
endmodule

// File: rtl/phase_rotator.sv
module phase_rotator (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seq_active,
  input  logic       pulse_req,
  input  logic [2:0] cfg_last_ph,
  input  logic       cfg_unused_low,
  output logic [7:0] hs_out,
  output logic [7:0] hs_oe
);
  import phs_pkg::*;

  ph_idx_t cur_idx;
  logic    accepted;
  ph_vec_t pulse_vec;
  ph_vec_t oe_vec;

  phs_counter #(.NPH(NPH)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_active (seq_active),
    .req        (pulse_req),
    .last       (cfg_last_ph),
    .idx_o      (cur_idx),
    .acc_o      (accepted)
  );

  phs_onehot #(.NPH(NPH)) u_dec (
    .idx (cur_idx),
    .en  (accepted),
    .vec (pulse_vec)
  );

  phs_oe_mask #(.NPH(NPH)) u_oe (
    .last      (cfg_last_ph),
    .force_low (cfg_unused_low),
    .oe        (oe_vec)
  );

  assign hs_out = pulse_vec;
  assign hs_oe  = oe_vec;

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hs_out));

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pulse_req && seq_active) |-> hs_out == '0);

  p_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_req && seq_active) |-> $countones(hs_out) == 1);

  p_drive_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_out & ~hs_oe) == '0);

  p_unused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_out >> cfg_last_ph) <= 8'd1);
endmodule

// File: tb/sim_phase_rotator.sv
module sim_phase_rotator;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seq_active = 1'b0;
  logic       pulse_req = 1'b0;
  logic [2:0] cfg_last_ph = 3'd7;
  logic       cfg_unused_low = 1'b0;
  logic [7:0] hs_out;
  logic [7:0] hs_oe;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_idx = 0;
  bit done = 1'b0;

  phase_rotator u0 (
    .clk(clk), .rst_n(rst_n), .seq_active(seq_active), .pulse_req(pulse_req),
    .cfg_last_ph(cfg_last_ph), .cfg_unused_low(cfg_unused_low),
    .hs_out(hs_out), .hs_oe(hs_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one accepted pulse of len cycles; checks every cycle and updates the model
  task automatic pulse(input string req, input int len);
    int eff;
    eff = (exp_idx > int'(cfg_last_ph)) ? 0 : exp_idx;
    @(negedge clk);
    pulse_req = 1'b1;
    for (int c = 0; c < len; c++) begin
      #1 check8(req, hs_out, 8'(1 << eff));
      @(negedge clk);
    end
    pulse_req = 1'b0;
    #1 check8(req, hs_out, 8'h00);
    exp_idx = (eff == int'(cfg_last_ph)) ? 0 : eff + 1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    #1 check8("R1 reset", hs_out, 8'h00);
    rst_n = 1'b1;
    seq_active = 1'b1;
    exp_idx = 0;
    pulse("R1 first pulse", 1);
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 8; k++) begin
      seq_active = 1'b0;
      @(negedge clk);
      seq_active = 1'b1;
      cfg_last_ph = 3'(k);
      exp_idx = 0;
      for (int p = 0; p < 2 * (k + 1) + 1; p++) pulse("R3 R4 rotation", 1);
    end
  endtask

  task automatic t_long;
    cfg_last_ph = 3'd3;
    pulse("R9 long pulse", 4);
    pulse("R9 long pulse", 3);
  endtask

  task automatic t_shrink;
    seq_active = 1'b0;
    @(negedge clk);
    seq_active = 1'b1;
    cfg_last_ph = 3'd7;
    exp_idx = 0;
    for (int p = 0; p < 6; p++) pulse("R3 pre-shrink", 1);
    cfg_last_ph = 3'd2;
    pulse("R5 shrink to 0", 1);
    pulse("R5 continue", 1);
  endtask

  task automatic t_seq_off;
    cfg_last_ph = 3'd7;
    pulse("R3 pre-off", 1);
    pulse("R3 pre-off", 1);
    @(negedge clk);
    seq_active = 1'b0;
    pulse_req = 1'b1;
    #1 check8("R6 off pulse ignored", hs_out, 8'h00);
    @(negedge clk);
    #1 check8("R6 off pulse ignored", hs_out, 8'h00);
    @(negedge clk);
    pulse_req = 1'b0;
    @(negedge clk);
    seq_active = 1'b1;
    exp_idx = 0;
    pulse("R6 restart at phase 0", 1);
  endtask

  task automatic t_oe;
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < 8; k++) begin
        cfg_unused_low = f[0];
        cfg_last_ph = 3'(k);
        #1 check8("R7 R8 enable mask", hs_oe,
                  f[0] ? 8'hFF : 8'((16'h1 << (k + 1)) - 1));
      end
    end
    cfg_unused_low = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_sweep();
    t_long();
    t_shrink();
    t_seq_off();
    t_oe();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule